// File: doc/BRIEF.md
# Ternary Error Event Encoder

This block turns a signed error value for one neuron into a stream of unit learning events. Each accepted error is divided by the current layer threshold. The integer quotient of the magnitude gives the number of events. The sign of the error gives their polarity. Every event leaves on a valid/ready channel along with the address of the neuron it belongs to. The valid signal of that channel acts as the update strobe. The polarity bit selects between depressing and potentiating the synapses of that neuron.

The threshold regulates itself. A window counter tallies the events that complete a handshake. On a batch-end pulse the threshold is moved by the signed gap between that tally and a target count, scaled down by a power-of-two gain. It is then limited to the range 1 to its all-ones value. A high event rate therefore makes the threshold coarser, and a low rate makes it finer. The division is sequential, so the block takes a new error only when both the divider and the event serializer are empty.

Top module: `terr_encoder`

## Requirements
- R1: An accepted error `err_value` with magnitude m and threshold t produces exactly floor(m / t) events, each carrying the address `err_addr` given with it. `ev_polarity` is 1 (depress) for a positive error and 0 (potentiate) for a negative one.
- R2: When floor(m / t) is zero, no event is produced and `err_ready` returns high once the division ends. No event appears in the cycle after an acceptance.
- R3: A quotient above one is sent as that many separate handshakes of the same address and polarity. While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_addr` and `ev_polarity` hold steady.
- R4: `err_ready` is low from the cycle after an acceptance until the division and all of its events are finished. An `err_value` offered while `err_ready` is low has no effect.
- R5: After reset `theta_out` equals the parameter TH_INIT, `ev_valid` is low and `err_ready` is high.
- R6: In the cycle after `batch_end` is high, `theta_out` becomes theta + floor((observed − `batch_target`) / 2^GAIN_SH), where observed is the number of event handshakes in the window. `theta_out` does not change in any other cycle.
- R7: The new threshold is limited to at least 1 and at most 2^TH_W − 1.
- R8: An event handshake in the same cycle as `batch_end` counts toward the window that is ending. The next window starts from zero.
- R9: Each error is divided by the threshold in force in the cycle it is accepted, even if the threshold changes while the division is in progress.
- R10: The most negative `err_value` (−2^(ERR_W−1)) is handled with magnitude 2^(ERR_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error value offered |
| err_ready | output | 1 | Block can accept an error |
| err_value | input | ERR_W | Signed error, two's complement |
| err_addr | input | ADDR_W | Neuron address of the error |
| batch_end | input | 1 | Closes the counting window and updates the threshold |
| batch_target | input | CNT_W | Set-point event count per window |
| ev_valid | output | 1 | Update strobe: an event is presented |
| ev_ready | input | 1 | Consumer takes the event |
| ev_addr | output | ADDR_W | Neuron address of the event |
| ev_polarity | output | 1 | 1 = depress, 0 = potentiate |
| theta_out | output | TH_W | Current threshold |

## Verification
The errors tried are a positive value with a multi-event quotient and a negative one. Values just under the threshold and exactly on it, in both signs, separate the zero-event case from the one-event case. A large magnitude at the smallest threshold and the most negative input check the quotient width and the handling of the sign. The consumer's ready is switched between always-high and a pseudo-random stall pattern, which tests that stalled events hold steady and that back-pressure never drops or duplicates an event. Batch closes are set to move the threshold down, to hit the lower clamp and the upper clamp, and to land while a division is in flight or an event is mid-handshake. These cases separate the threshold captured at acceptance from the current one, and show which window a coincident event belongs to.

// File: rtl/terr_pkg.sv
package terr_pkg;

  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_DONE = 2'd2
  } div_state_e;

endpackage

// File: rtl/terr_divider.sv
module terr_divider #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             idle,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  import terr_pkg::*;

  localparam int SC_W = $clog2(NUM_W + 1);

  div_state_e       state_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] q_q;
  logic [SC_W-1:0]  step_q;

  // one restoring step: shift in next dividend bit, subtract if it fits
  function automatic logic [DEN_W:0] restore_step(
    input logic [DEN_W-1:0] rem,
    input logic             nbit,
    input logic [DEN_W-1:0] d
  );
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    trial = {rem, nbit};
    diff  = trial - {1'b0, d};
    if (trial >= {1'b0, d}) return {1'b1, diff[DEN_W-1:0]};
    else                    return {1'b0, trial[DEN_W-1:0]};
  endfunction

  logic [DEN_W:0] step_res;
  assign step_res = restore_step(rem_q, q_q[NUM_W-1], den_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      rem_q   <= '0;
      den_q   <= '0;
      q_q     <= '0;
      step_q  <= '0;
    end else begin
      case (state_q)
        DIV_IDLE: if (start) begin
          state_q <= DIV_RUN;
          rem_q   <= '0;
          den_q   <= den;
          q_q     <= num;
          step_q  <= SC_W'(NUM_W);
        end
        DIV_RUN: begin
          rem_q  <= step_res[DEN_W-1:0];
          q_q    <= {q_q[NUM_W-2:0], step_res[DEN_W]};
          step_q <= step_q - 1'b1;
          if (step_q == SC_W'(1)) state_q <= DIV_DONE;
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign idle = (state_q == DIV_IDLE);
  assign done = (state_q == DIV_DONE);
  assign quot = q_q;

endmodule

// File: rtl/terr_serializer.sv
module terr_serializer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              load_pol,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              ev_ready,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  output logic              ev_pol,
  output logic              active,
  output logic              fire
);
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pol_q;

  assign active   = (left_q != '0);
  assign ev_valid = active;
  assign fire     = active && ev_ready;
  assign ev_addr  = addr_q;
  assign ev_pol   = pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
      pol_q  <= 1'b0;
    end else if (load) begin
      left_q <= load_count;
      addr_q <= load_addr;
      pol_q  <= load_pol;
    end else if (fire) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/terr_rate_ctrl.sv
module terr_rate_ctrl #(
  parameter int TH_W    = 12,
  parameter int CNT_W   = 16,
  parameter int GAIN_SH = 2,
  parameter int TH_INIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             batch_end,
  input  logic [CNT_W-1:0] target,
  output logic [TH_W-1:0]  theta
);
  localparam int SW = ((CNT_W > TH_W) ? CNT_W : TH_W) + 2;
  localparam logic signed [SW-1:0] S_ONE = SW'(1);
  localparam logic signed [SW-1:0] S_MAX = SW'((1 << TH_W) - 1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic logic [TH_W-1:0] next_theta(
    input logic [TH_W-1:0]  th,
    input logic [CNT_W-1:0] obs,
    input logic [CNT_W-1:0] tgt
  );
    logic signed [SW-1:0] gap;
    logic signed [SW-1:0] adj;
    logic signed [SW-1:0] sum;
    gap = $signed(SW'(obs)) - $signed(SW'(tgt));
    adj = gap >>> GAIN_SH;
    sum = $signed(SW'(th)) + adj;
    if (sum < S_ONE)      return TH_W'(1);
    else if (sum > S_MAX) return TH_W'(S_MAX);
    else                  return TH_W'(sum);
  endfunction

  logic [CNT_W-1:0] win_q;
  logic [CNT_W-1:0] observed;
  logic [TH_W-1:0]  theta_q;

  assign observed = fire ? sat_inc(win_q) : win_q;
  assign theta    = theta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= '0;
      theta_q <= TH_W'(TH_INIT);
    end else if (batch_end) begin
      win_q   <= '0;
      theta_q <= next_theta(theta_q, observed, target);
    end else if (fire) begin
      win_q   <= sat_inc(win_q);
    end
  end

endmodule

// File: rtl/terr_encoder.sv
module terr_encoder #(
  parameter int ERR_W   = 16,
  parameter int TH_W    = 12,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int GAIN_SH = 2,
  parameter int TH_INIT = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     err_valid,
  output logic                     err_ready,
  input  logic signed [ERR_W-1:0]  err_value,
  input  logic [ADDR_W-1:0]        err_addr,
  input  logic                     batch_end,
  input  logic [CNT_W-1:0]         batch_target,
  output logic                     ev_valid,
  input  logic                     ev_ready,
  output logic [ADDR_W-1:0]        ev_addr,
  output logic                     ev_polarity,
  output logic [TH_W-1:0]          theta_out
);
  // magnitude of a two's complement value, full range incl. most negative
  function automatic logic [ERR_W-1:0] err_mag(input logic signed [ERR_W-1:0] v);
    return v[ERR_W-1] ? (~v + 1'b1) : v;
  endfunction

  logic              accept;
  logic              div_idle;
  logic              div_done;
  logic [ERR_W-1:0]  div_quot;
  logic              ser_load;
  logic              ser_active;
  logic              ev_fire;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_pol_q;

  assign err_ready = div_idle && !ser_active;
  assign accept    = err_valid && err_ready;
  assign ser_load  = div_done && (div_quot != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
      pend_pol_q  <= 1'b0;
    end else if (accept) begin
      pend_addr_q <= err_addr;
      pend_pol_q  <= !err_value[ERR_W-1] && (err_value != '0);
    end
  end

  terr_divider #(
    .NUM_W(ERR_W),
    .DEN_W(TH_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .num  (err_mag(err_value)),
    .den  (theta_out),
    .idle (div_idle),
    .done (div_done),
    .quot (div_quot)
  );

  terr_serializer #(
    .CNT_W (ERR_W),
    .ADDR_W(ADDR_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ser_load),
    .load_count(div_quot),
    .load_pol  (pend_pol_q),
    .load_addr (pend_addr_q),
    .ev_ready  (ev_ready),
    .ev_valid  (ev_valid),
    .ev_addr   (ev_addr),
    .ev_pol    (ev_polarity),
    .active    (ser_active),
    .fire      (ev_fire)
  );

  terr_rate_ctrl #(
    .TH_W   (TH_W),
    .CNT_W  (CNT_W),
    .GAIN_SH(GAIN_SH),
    .TH_INIT(TH_INIT)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (ev_fire),
    .batch_end(batch_end),
    .target   (batch_target),
    .theta    (theta_out)
  );

endmodule

// File: rtl/terr_encoder_checker.sv
module terr_encoder_checker #(
  parameter int ERR_W  = 16,
  parameter int TH_W   = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_valid,
  input logic              err_ready,
  input logic              batch_end,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [ADDR_W-1:0] ev_addr,
  input logic              ev_polarity,
  input logic [TH_W-1:0]   theta_out,
  input logic              div_done,
  input logic [ERR_W-1:0]  div_quot
);

  p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_addr) && $stable(ev_polarity));

  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && err_ready |=> !err_ready);

  p_no_early_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && err_ready |=> !ev_valid);

  p_zero_quot_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_done && (div_quot == '0) |=> err_ready && !ev_valid);

  p_theta_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    theta_out != '0);

  p_theta_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !batch_end |=> $stable(theta_out));

endmodule

bind terr_encoder terr_encoder_checker #(
  .ERR_W (ERR_W),
  .TH_W  (TH_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .err_valid  (err_valid),
  .err_ready  (err_ready),
  .batch_end  (batch_end),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .ev_addr    (ev_addr),
  .ev_polarity(ev_polarity),
  .theta_out  (theta_out),
  .div_done   (div_done),
  .div_quot   (div_quot)
);

// File: tb/terr_encoder_bench.sv
module terr_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W   = 12;
  localparam int TH_W    = 8;
  localparam int ADDR_W  = 6;
  localparam int CNT_W   = 12;
  localparam int GAIN_SH = 1;
  localparam int TH_INIT = 64;
  localparam int TH_MAX  = (1 << TH_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 1'b0;
  logic err_ready;
  logic signed [ERR_W-1:0] err_value = '0;
  logic [ADDR_W-1:0] err_addr = '0;
  logic batch_end = 1'b0;
  logic [CNT_W-1:0] batch_target = '0;
  logic ev_valid;
  logic ev_ready = 1'b1;
  logic [ADDR_W-1:0] ev_addr;
  logic ev_polarity;
  logic [TH_W-1:0] theta_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [ADDR_W:0] exp_q[$];
  int  theta_m = TH_INIT;
  int  win_cnt = 0;
  int  pend_theta = 0;
  bit  upd_pend = 0;
  bit  rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit  prev_stall = 0;
  logic [ADDR_W-1:0] prev_addr = '0;
  logic prev_pol = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  terr_encoder #(
    .ERR_W(ERR_W), .TH_W(TH_W), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .GAIN_SH(GAIN_SH), .TH_INIT(TH_INIT)
  ) u_terr_encoder (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_ready(err_ready),
    .err_value(err_value), .err_addr(err_addr),
    .batch_end(batch_end), .batch_target(batch_target),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_addr(ev_addr), .ev_polarity(ev_polarity),
    .theta_out(theta_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // floor division by 2^GAIN_SH, written without shifts
  function automatic int floor_div(input int d);
    int p;
    p = 1 << GAIN_SH;
    if (d >= 0) return d / p;
    return -((-d + p - 1) / p);
  endfunction

  function automatic int model_theta(input int th, input int obs, input int tgt);
    int s;
    s = th + floor_div(obs - tgt);
    if (s < 1) s = 1;
    if (s > TH_MAX) s = TH_MAX;
    return s;
  endfunction

  // consumer back-pressure
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ev_ready <= rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_pend) begin
        theta_m = pend_theta;
        upd_pend = 0;
        check(int'(theta_out) == theta_m, "R6/R7 theta after batch", int'(theta_out), theta_m);
      end
      if (prev_stall)
        check(ev_valid && ev_addr == prev_addr && ev_polarity == prev_pol,
              "R3 stalled event held", int'(ev_addr), int'(prev_addr));
      if (ev_valid && ev_ready) begin
        win_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1/R2 unexpected event", int'(ev_addr), -1);
        end else begin
          logic [ADDR_W:0] e;
          e = exp_q.pop_front();
          check({ev_polarity, ev_addr} == e, "R1/R3 event addr/polarity",
                int'({ev_polarity, ev_addr}), int'(e));
        end
      end
      if (batch_end) begin
        // R8: a coincident handshake was already added above
        pend_theta = model_theta(theta_m, win_cnt, int'(batch_target));
        upd_pend = 1;
        win_cnt = 0;
      end
      prev_stall = ev_valid && !ev_ready;
      prev_addr  = ev_addr;
      prev_pol   = ev_polarity;
    end
  end

  task automatic send_err(input int v, input int a);
    int th;
    int mag;
    int n;
    @(posedge clk);
    err_value <= ERR_W'(v);
    err_addr  <= ADDR_W'(a);
    err_valid <= 1'b1;
    @(negedge clk);
    while (!err_ready) @(negedge clk);
    th  = int'(theta_out);   // R9: threshold in force at acceptance
    mag = (v < 0) ? -v : v;
    n   = mag / th;
    for (int i = 0; i < n; i++) exp_q.push_back({(v > 0) ? 1'b1 : 1'b0, ADDR_W'(a)});
    @(posedge clk);
    err_valid <= 1'b0;
  endtask

  task automatic pulse_batch(input int tgt);
    @(posedge clk);
    batch_end    <= 1'b1;
    batch_target <= CNT_W'(tgt);
    @(posedge clk);
    batch_end    <= 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(err_ready && exp_q.size() == 0)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    check(int'(theta_out) == TH_INIT, "R5 theta reset", int'(theta_out), TH_INIT);
    check(!ev_valid, "R5 no event at reset", int'(ev_valid), 0);
    check(err_ready, "R5 ready at reset", int'(err_ready), 1);

    // R1/R3: positive multi-event, negative two-event, stalling consumer
    rdy_rand = 1;
    send_err(300, 5);
    wait_idle();
    send_err(-130, 9);
    wait_idle();

    // R2: sub-threshold both signs, then exact boundary both signs
    send_err(63, 3);
    repeat (ERR_W + 6) @(negedge clk);
    check(!ev_valid && err_ready, "R2 sub-threshold gives no event", int'(ev_valid), 0);
    send_err(-63, 4);
    wait_idle();
    send_err(64, 7);
    wait_idle();
    send_err(-64, 8);
    wait_idle();

    // R4: offer a different error while busy; it must be ignored
    send_err(200, 11);
    @(posedge clk);
    err_value <= ERR_W'(2000);
    err_addr  <= ADDR_W'(12);
    err_valid <= 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!err_ready, "R4 not ready while dividing", int'(err_ready), 0);
    end
    @(posedge clk);
    err_valid <= 1'b0;
    wait_idle();

    // R6: raise then lower theta
    pulse_batch(0);
    wait_idle();
    pulse_batch(100);
    wait_idle();
    send_err(2047, 20);
    wait_idle();

    // R9 + R7 lower clamp: batch lands during division
    send_err(1000, 21);
    repeat (3) @(posedge clk);
    pulse_batch(2000);
    wait_idle();
    check(int'(theta_out) == 1, "R7 lower clamp", int'(theta_out), 1);

    // R10 most negative input at theta 1; R8 + R7 upper clamp mid-stream
    rdy_rand = 0;
    send_err(-(1 << (ERR_W - 1)), 33);
    repeat (600) @(posedge clk);
    pulse_batch(0);
    rdy_rand = 1;
    wait_idle();
    check(int'(theta_out) == TH_MAX, "R7 upper clamp", int'(theta_out), TH_MAX);
    pulse_batch(0);
    wait_idle();

    send_err(2047, 40);
    wait_idle();
    pulse_batch(20);
    wait_idle();

    check(exp_q.size() == 0, "R1 all expected events seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule